// File: doc/BRIEF.md
# Single-Line Startup Mode Selector

This block watches one control line after power-up and turns its timing into an operating state for a boost LED driver. A rising line wakes the block. When the line has stayed high for a short setup time, a selection window opens. Inside that window a specific pattern selects digital-command mode: a long first high phase followed by a long low phase. If the pattern does not appear, analog PWM dimming is chosen instead. When the window closes, a fixed delay runs and then the converter enable is raised.

After startup the line carries either PWM or commands, so it toggles freely. Only a low phase that lasts for the full shutdown time returns the block to shutdown. That drops the enable and forgets the mode.

All timing is counted in ticks of a one-microsecond strobe, `us_tick`. The block also pulses `restart_pulse` for one cycle each time it leaves shutdown. A fault supervisor uses this pulse to re-arm itself.

Top module: `line_mode_sel`

## Requirements
- R1: While reset is asserted, and right after it is released, `mode_digital`, `conv_en` and `restart_pulse` are all 0 and the block is in shutdown.
- R2: From shutdown, the line must stay high for T_SETUP ticks before the selection window opens. A shorter high pulse returns the block to shutdown, and `conv_en` stays 0.
- R3: Every move from shutdown into the wake state drives `restart_pulse` high for exactly one clock cycle. This includes wakes that end early.
- R4: The selection window lasts T_SEL ticks from its opening. The mode is latched when the window closes, and `mode_digital` reads 0 until then.
- R5: Digital mode (`mode_digital` = 1) is selected under two conditions. First, the first high phase, counted from the rising edge that woke the block, must last more than T_HIGH_MIN ticks. Second, the low phase that follows must reach T_LOW_DIG ticks before the window closes.
- R6: In every other case the mode is PWM (`mode_digital` = 0). This covers:
  - a high phase that is too short;
  - a low phase that ends too early;
  - a pattern that finishes after the window.

  Only the first high/low attempt after a wake counts.
- R7: `conv_en` rises T_DEL ticks after the selection window closes. This delay is the same in both modes.
- R8: After startup, if the line stays low for T_OFF consecutive ticks, the block returns to shutdown. `conv_en` and `mode_digital` both fall to 0.
- R9: Low phases shorter than T_OFF, such as PWM or command traffic, never change `conv_en` or `mode_digital`.
- R10: Once latched, `mode_digital` stays constant until the next shutdown.
- R11: Timers advance only on cycles where `us_tick` is 1. A low line with no ticks does not cause a shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| line_in | input | 1 | Asynchronous control line |
| mode_digital | output | 1 | 1 = digital-command mode, 0 = PWM mode |
| conv_en | output | 1 | Boost converter enable |
| restart_pulse | output | 1 | One-cycle pulse on each exit from shutdown |

## Verification
The assertions check four properties on every cycle:
- `restart_pulse` is one cycle wide and only ever coincides with the wake state.
- The enable is 0 during selection, and it falls only after the synchronized line was low.
- The mode stays constant while the converter runs.
- The pattern detector reaches its hit state only from its low phase, and a miss stays a miss until the next restart.

Three things are shown only by the bench's timed scenarios:
- the absolute tick counts of setup, window, delay and shutdown;
- the sweep of high and low phase lengths against the digital/PWM decision;
- the effect of gated ticks.

// File: rtl/lms_pkg.sv
package lms_pkg;

  typedef enum logic [2:0] {
    ST_SHUT   = 3'd0,
    ST_WAKE   = 3'd1,
    ST_SELECT = 3'd2,
    ST_DELAY  = 3'd3,
    ST_RUN    = 3'd4
  } lms_state_e;

  typedef enum logic [1:0] {
    PH_HIGH = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIT  = 2'd2,
    PH_MISS = 2'd3
  } lms_phase_e;

endpackage

// File: rtl/lms_sync.sv
module lms_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("lms_sync needs at least two stages");
  end

endmodule

// File: rtl/lms_timer.sv
module lms_timer #(
  parameter int MAXV = 15,
  parameter int W    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] LIM = W'(MAXV);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                      cnt_d = '0;
    else if (inc && cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/lms_pattern.sv
module lms_pattern
  import lms_pkg::*;
#(
  parameter int HMIN = 100,
  parameter int LMIN = 260
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic tick,
  input  logic line,
  output logic hit
);

  localparam int PMAX = (HMIN + 1 > LMIN) ? HMIN + 1 : LMIN;
  localparam int PW   = $clog2(PMAX + 1);
  localparam logic [PW-1:0] HLIM = PW'(HMIN);
  localparam logic [PW-1:0] LLIM = PW'(LMIN);

  lms_phase_e    phase_q, phase_d;
  logic [PW-1:0] ph_cnt;
  logic          ph_inc, ph_clr;

  always_comb begin
    phase_d = phase_q;
    if (restart) begin
      phase_d = PH_HIGH;
    end else if (active) begin
      case (phase_q)
        PH_HIGH: if (!line) phase_d = (ph_cnt > HLIM) ? PH_LOW : PH_MISS;
        PH_LOW: begin
          if (line)                phase_d = PH_MISS;
          else if (ph_cnt >= LLIM) phase_d = PH_HIT;
        end
        default: phase_d = phase_q;
      endcase
    end
  end

  always_comb begin
    ph_clr = restart || (phase_d != phase_q);
    ph_inc = 1'b0;
    if (active && tick) begin
      if (phase_q == PH_HIGH) ph_inc = line;
      else if (phase_q == PH_LOW) ph_inc = !line;
    end
  end

  lms_timer #(.MAXV(PMAX), .W(PW)) u_phase_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ph_clr),
    .inc   (ph_inc),
    .cnt   (ph_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_MISS;
    else        phase_q <= phase_d;
  end

  assign hit = (phase_q == PH_HIT);

  assert_hit_from_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(phase_q == PH_LOW));

  assert_miss_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MISS && !restart) |=> (phase_q == PH_MISS));

endmodule

// File: rtl/line_mode_sel.sv
module line_mode_sel
  import lms_pkg::*;
#(
  parameter int T_SETUP     = 2,
  parameter int T_SEL       = 1000,
  parameter int T_HIGH_MIN  = 100,
  parameter int T_LOW_DIG   = 260,
  parameter int T_DEL       = 2000,
  parameter int T_OFF       = 8900,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic line_in,
  output logic mode_digital,
  output logic conv_en,
  output logic restart_pulse
);

  localparam int ST_MAX0 = (T_SETUP > T_SEL) ? T_SETUP : T_SEL;
  localparam int ST_MAX  = (ST_MAX0 > T_DEL) ? ST_MAX0 : T_DEL;
  localparam int SW      = $clog2(ST_MAX + 1);
  localparam int OW      = $clog2(T_OFF + 1);
  localparam logic [SW-1:0] SETUP_L = SW'(T_SETUP);
  localparam logic [SW-1:0] SEL_L   = SW'(T_SEL);
  localparam logic [SW-1:0] DEL_L   = SW'(T_DEL);
  localparam logic [OW-1:0] OFF_L   = OW'(T_OFF);

  lms_state_e    state_q, state_d;
  logic          line_s;
  logic [SW-1:0] st_cnt;
  logic [OW-1:0] low_cnt;
  logic          state_chg, st_inc, low_inc, low_clr;
  logic          wake_go, pat_hit, pat_active;
  logic          mode_q, mode_d, mode_en;
  logic          en_q, pulse_q;

  lms_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_in),
    .q     (line_s)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_SHUT:   if (line_s) state_d = ST_WAKE;
      ST_WAKE: begin
        if (!line_s)               state_d = ST_SHUT;
        else if (st_cnt >= SETUP_L) state_d = ST_SELECT;
      end
      ST_SELECT: if (st_cnt >= SEL_L) state_d = ST_DELAY;
      ST_DELAY: begin
        if (low_cnt >= OFF_L)     state_d = ST_SHUT;
        else if (st_cnt >= DEL_L) state_d = ST_RUN;
      end
      ST_RUN:    if (low_cnt >= OFF_L) state_d = ST_SHUT;
      default:   state_d = ST_SHUT;
    endcase
  end

  assign state_chg  = (state_d != state_q);
  assign wake_go    = (state_q == ST_SHUT) && (state_d == ST_WAKE);
  assign st_inc     = us_tick && (state_q inside {ST_WAKE, ST_SELECT, ST_DELAY});
  assign low_inc    = us_tick && !line_s;
  assign low_clr    = state_chg || line_s || !(state_q inside {ST_DELAY, ST_RUN});
  assign pat_active = (state_q inside {ST_WAKE, ST_SELECT});

  lms_timer #(.MAXV(ST_MAX), .W(SW)) u_state_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_chg),
    .inc   (st_inc),
    .cnt   (st_cnt)
  );

  lms_timer #(.MAXV(T_OFF), .W(OW)) u_low_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (low_clr),
    .inc   (low_inc),
    .cnt   (low_cnt)
  );

  lms_pattern #(.HMIN(T_HIGH_MIN), .LMIN(T_LOW_DIG)) u_pattern (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wake_go),
    .active  (pat_active),
    .tick    (us_tick),
    .line    (line_s),
    .hit     (pat_hit)
  );

  // mode latch: loaded when the window closes, cleared on shutdown
  assign mode_en = state_chg && (state_d inside {ST_DELAY, ST_SHUT});
  assign mode_d  = (state_d == ST_DELAY) ? pat_hit : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SHUT;
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (mode_en) mode_q <= mode_d;
      en_q    <= (state_d == ST_RUN);
      pulse_q <= wake_go;
    end
  end

  assign mode_digital  = mode_q;
  assign conv_en       = en_q;
  assign restart_pulse = pulse_q;

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse);

  assert_pulse_in_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> (state_q == ST_WAKE));

  assert_no_en_in_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SELECT) |-> !conv_en);

  assert_en_drop_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_en) |-> $past(!line_s));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && $past(conv_en)) |-> $stable(mode_digital));

endmodule

// File: tb/line_mode_sel_tb.sv
`timescale 1ns/1ps
module line_mode_sel_tb;

  localparam int S    = 3;
  localparam int W    = 60;
  localparam int HMIN = 12;
  localparam int LDIG = 16;
  localparam int D    = 30;
  localparam int OFF  = 80;
  localparam int BASE = 6 + S + W + D;  // cycles from rising line to conv_en

  logic clk = 1'b0;
  logic rst_n;
  logic us_tick;
  logic line_in;
  logic mode_digital, conv_en, restart_pulse;

  int checks = 0;
  int fails  = 0;
  int pulse_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  line_mode_sel #(
    .T_SETUP(S), .T_SEL(W), .T_HIGH_MIN(HMIN), .T_LOW_DIG(LDIG),
    .T_DEL(D), .T_OFF(OFF), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .line_in(line_in),
    .mode_digital(mode_digital), .conv_en(conv_en), .restart_pulse(restart_pulse)
  );

  always @(negedge clk) if (restart_pulse) pulse_cnt <= pulse_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wake with high h1 / low l1 / high h2 / low l2, then line high
  task automatic startup(input int h1, input int l1, input int h2, input int l2,
                         input bit exp_dig);
    int p0;
    p0 = pulse_cnt;
    line_in = 1'b1; cyc(h1);
    line_in = 1'b0; cyc(l1);
    line_in = 1'b1;
    if (h2 > 0) begin
      cyc(h2); line_in = 1'b0; cyc(l2); line_in = 1'b1;
    end
    cyc(BASE - 3 - h1 - l1 - h2 - l2);
    chk(conv_en == 1'b0, "R7 enable still low before delay end", conv_en, 0);
    cyc(6);
    chk(conv_en == 1'b1, "R7 enable high after delay", conv_en, 1);
    chk(mode_digital == exp_dig, "R5/R6 selected mode", mode_digital, exp_dig);
    chk(pulse_cnt - p0 == 1, "R3 one restart pulse per wake", pulse_cnt - p0, 1);
    // R9: traffic with lows shorter than the shutdown time
    for (int k = 0; k < 3; k++) begin
      line_in = 1'b0; cyc(30);
      line_in = 1'b1; cyc(10);
      chk(conv_en == 1'b1 && mode_digital == exp_dig, "R9 R10 state kept under traffic",
          {conv_en, mode_digital}, {1'b1, exp_dig});
    end
  endtask

  task automatic shutdown();
    line_in = 1'b0;
    cyc(OFF);
    chk(conv_en == 1'b1, "R8 enable held before low time elapses", conv_en, 1);
    cyc(6);
    chk(conv_en == 1'b0, "R8 enable dropped", conv_en, 0);
    chk(mode_digital == 1'b0, "R8 mode cleared", mode_digital, 0);
    cyc(5);
  endtask

  initial begin
    int hs[8] = '{6, 10, 16, 22, 30, 44, 56, 70};
    int ls[4] = '{8, 12, 20, 28};
    rst_n = 1'b0; us_tick = 1'b1; line_in = 1'b0;
    cyc(3);
    chk(conv_en == 0 && mode_digital == 0 && restart_pulse == 0, "R1 reset outputs",
        {conv_en, mode_digital, restart_pulse}, 0);
    rst_n = 1'b1;
    cyc(3);
    chk(conv_en == 0 && mode_digital == 0 && restart_pulse == 0, "R1 after release",
        {conv_en, mode_digital, restart_pulse}, 0);

    // R2: high pulses shorter than setup time
    for (int g = 1; g <= 2; g++) begin
      int p0;
      p0 = pulse_cnt;
      line_in = 1'b1; cyc(g); line_in = 1'b0;
      cyc(BASE + 5);
      chk(conv_en == 1'b0, "R2 short high does not start", conv_en, 0);
      chk(pulse_cnt - p0 == 1, "R3 pulse on aborted wake", pulse_cnt - p0, 1);
    end

    // R4 R5 R6 sweep over first high and low phase lengths
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 4; j++) begin
        bit e;
        if (hs[i] + ls[j] <= 90) begin
          e = (hs[i] >= 16) && (ls[j] >= 20) && (hs[i] <= 44);
          startup(hs[i], ls[j], 0, 0, e);
          shutdown();
        end
      end
    end

    // R6: second attempt after a too-short low does not count
    startup(20, 8, 6, 25, 1'b0);
    shutdown();

    // R11: no ticks, long low does not shut down
    startup(20, 24, 0, 0, 1'b1);
    us_tick = 1'b0; line_in = 1'b0;
    cyc(3 * OFF);
    chk(conv_en == 1'b1, "R11 no tick no shutdown", conv_en, 1);
    chk(mode_digital == 1'b1, "R11 mode kept without ticks", mode_digital, 1);
    line_in = 1'b1; cyc(4); us_tick = 1'b1; cyc(2);
    shutdown();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule